// File: doc/BRIEF.md
# Processor Access Holdoff Controller

This block sits between an asynchronous microprocessor bus and a small internal register file. The bus presents an active-low chip select, an active-low read strobe and an active-low write strobe. All three pass through a two-stage synchronizer. Once an access is accepted, a fixed four-cycle internal operation reads or writes the register file. The block then drives an active-low acknowledge. Acknowledge stays low until chip select is released.

When an access finishes, a saturating gap counter restarts from zero. A new access is not accepted until that counter has counted back up to its terminal value. A request that arrives earlier is held off without any error: its acknowledge simply comes later. A status output, `holdoff`, is high while the gap is being counted.

A software-reset bit from a command register bypasses the gap completely. While it is set, accesses are accepted at once, the status output stays low, and finished accesses do not restart the counter.

Top module: `holdoff_ctrl`

## Requirements
- R1: With no gap pending, acknowledge goes low between 5 and 7 clock cycles after the later of chip select and strobe becomes active. This delay includes two synchronizer stages and a 4-cycle internal operation.
- R2: Acknowledge stays low while chip select is held low. It returns high exactly 3 cycles after chip select is released.
- R3: When an access ends (acknowledge returns high) with software reset clear, `holdoff` goes high in the same cycle and stays high for exactly 20 cycles.
- R4: A request made while the gap is being counted is stalled until the count completes. An access that immediately follows another sees acknowledge 23 to 29 cycles after its strobe.
- R5: After power-on reset the counter sits at its terminal count. `holdoff` is low and the first access is not delayed beyond 7 cycles.
- R6: While `sw_reset` is 1, `holdoff` is 0 and back-to-back accesses are each acknowledged within 7 cycles. An access completed under `sw_reset` leaves no gap pending once `sw_reset` returns to 0.
- R7: A write (write strobe low, read strobe high) stores `wdata` at `addr`. A read (read strobe low) returns the stored word on `rdata`. `rdata` stays stable for as long as acknowledge is low.
- R8: During reset, `ack_n` is 1 and `holdoff` is 0.
- R9: Acknowledge is never low while `holdoff` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | AW | Register file address, stable while the strobe is active |
| wdata | input | DW | Write data, stable while the strobe is active |
| sw_reset | input | 1 | Software-reset bit from the command register; disables the gap |
| ack_n | output | 1 | Access acknowledge, active low |
| rdata | output | DW | Read data, valid while acknowledge is low |
| holdoff | output | 1 | High while the inter-access gap is being counted |

## Verification
The assertions check the following on every cycle:
- acknowledge never coexists with `holdoff`;
- acknowledge cannot drop while chip select is still held;
- read data stays fixed during acknowledge;
- `holdoff` can only rise just after an acknowledge ends;
- acknowledge never arrives without chip select having been active seven cycles earlier.

Some properties need whole scenarios, checked by the bench's cycle-level model:
- the exact 20-cycle gap length;
- the 23-to-29-cycle stretch of a back-to-back access;
- the full bypass under software reset, including the absence of a leftover gap afterwards;
- the round trip of written data.

// File: rtl/holdoff_ctrl.sv
module holdoff_ctrl #(
  parameter int HOLD_CYCLES = 20,
  parameter int OP_CYCLES   = 4,
  parameter int AW          = 4,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          sw_reset,
  output logic          ack_n,
  output logic [DW-1:0] rdata,
  output logic          holdoff
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(HOLD_CYCLES + 1);
  localparam int OW    = $clog2(OP_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_END = CW'(HOLD_CYCLES);
  localparam logic [OW-1:0] OP_LAST  = OW'(OP_CYCLES - 1);

  typedef enum logic [1:0] {IDLE, BUSY, DONE} state_t;

  state_t         state;
  logic [2:0]     sync1, sync2;
  logic [CW-1:0]  gap_cnt;
  logic [OW-1:0]  op_cnt;
  logic           is_write;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [DW-1:0]  rdata_q;
  logic [DW-1:0]  regs [DEPTH];

  wire cs_s    = sync2[2];
  wire request = sync2[2] & (sync2[1] | sync2[0]);
  wire gap_ok  = sw_reset || (gap_cnt == HOLD_END);
  wire release_now = (state == DONE) && !cs_s;

  assign ack_n   = (state != DONE);
  assign rdata   = rdata_q;
  assign holdoff = !sw_reset && (gap_cnt != HOLD_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {~cs_n, ~rd_n, ~wr_n};
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gap_cnt <= HOLD_END;
    else if (sw_reset)
      gap_cnt <= HOLD_END;
    else if (release_now)
      gap_cnt <= '0;
    else if (gap_cnt != HOLD_END)
      gap_cnt <= gap_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IDLE;
      op_cnt   <= '0;
      is_write <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      case (state)
        IDLE: if (request && gap_ok) begin
          state    <= BUSY;
          op_cnt   <= '0;
          is_write <= sync2[0] && !sync2[1];
          addr_q   <= addr;
          wdata_q  <= wdata;
        end
        BUSY: if (op_cnt == OP_LAST) begin
          state <= DONE;
          if (is_write) regs[addr_q] <= wdata_q;
          else          rdata_q      <= regs[addr_q];
        end else begin
          op_cnt <= op_cnt + 1'b1;
        end
        DONE: if (!cs_s) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end
endmodule

module holdoff_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          ack_n,
  input logic          holdoff,
  input logic [DW-1:0] rdata
);
  assert_no_ack_in_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !holdoff);

  assert_ack_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !cs_n && !$past(cs_n)) |=> !ack_n);

  assert_rdata_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !$past(ack_n)) |-> $stable(rdata));

  assert_gap_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdoff) |-> !$past(ack_n));

  assert_min_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> !$past(cs_n, 7));
endmodule

bind holdoff_ctrl holdoff_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ack_n(ack_n),
  .holdoff(holdoff), .rdata(rdata)
);

// File: tb/holdoff_ctrl_bench.sv
module holdoff_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       sw_reset = 1'b0;
  logic       ack_n;
  logic [7:0] rdata;
  logic       holdoff;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  holdoff_ctrl u_holdoff_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .sw_reset(sw_reset),
    .ack_n(ack_n), .rdata(rdata), .holdoff(holdoff)
  );

  // behavioural reference: delay lines for the strobes, integer gap and phase
  bit   pipe_q[$];
  bit   rdq[$];
  bit   wrq[$];
  int   m_gap = 20;
  int   m_phase = 0;   // 0 waiting, 1 working, 2 acknowledging
  int   m_left = 0;
  bit   m_wr = 0;
  int   m_addr = 0;
  int   m_wd = 0;
  int   m_rd = 0;
  int   m_mem [16];

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      pipe_q = '{0, 0}; rdq = '{0, 0}; wrq = '{0, 0};
      m_gap = 20; m_phase = 0; m_left = 0; m_rd = 0;
      foreach (m_mem[i]) m_mem[i] = 0;
    end else begin
      bit cs_d, rd_d, wr_d;
      int next_gap;
      cs_d = pipe_q[0]; rd_d = rdq[0]; wr_d = wrq[0];
      if (sw_reset) next_gap = 20;
      else if (m_phase == 2 && !cs_d) next_gap = 0;
      else next_gap = (m_gap < 20) ? m_gap + 1 : 20;
      if (m_phase == 0) begin
        if (cs_d && (rd_d || wr_d) && (sw_reset || m_gap == 20)) begin
          m_phase = 1; m_left = 4; m_wr = wr_d && !rd_d;
          m_addr = int'(addr); m_wd = int'(wdata);
        end
      end else if (m_phase == 1) begin
        m_left--;
        if (m_left == 0) begin
          m_phase = 2;
          if (m_wr) m_mem[m_addr] = m_wd; else m_rd = m_mem[m_addr];
        end
      end else if (!cs_d) m_phase = 0;
      m_gap = next_gap;
      void'(pipe_q.pop_front()); pipe_q.push_back(!cs_n);
      void'(rdq.pop_front());    rdq.push_back(!rd_n);
      void'(wrq.pop_front());    wrq.push_back(!wr_n);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // per-cycle comparison against the model (R1 R2 R3 R4 R6 R7 R9)
  always @(negedge clk) begin
    if (rst_n) begin
      check("R1/R2/R4 ack_n model", int'(ack_n), (m_phase == 2) ? 0 : 1);
      check("R3/R6 holdoff model", int'(holdoff), (!sw_reset && m_gap < 20) ? 1 : 0);
      if (m_phase == 2 && !m_wr) check("R7 rdata model", int'(rdata), m_rd);
    end else begin
      check("R8 reset ack_n", int'(ack_n), 1);
      check("R8 reset holdoff", int'(holdoff), 0);
    end
  end

  task automatic access(input bit wr, input logic [3:0] a, input logic [7:0] d,
                        output int lat, output int rel, output int rd_val);
    @(negedge clk);
    cs_n = 1'b0; addr = a; wdata = d;
    if (wr) wr_n = 1'b0; else rd_n = 1'b0;
    lat = 0;
    while (ack_n) begin @(negedge clk); lat++; end
    rd_val = int'(rdata);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    rel = 0;
    while (!ack_n) begin @(negedge clk); rel++; end
  endtask

  initial begin
    int lat, rel, rv, hcount;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 holdoff low after reset", int'(holdoff), 0);

    access(1'b1, 4'd3, 8'h5A, lat, rel, rv);
    check_range("R1 first write latency", lat, 5, 7);
    check_range("R5 first access undelayed", lat, 0, 7);
    check("R2 release delay", rel, 3);
    hcount = 0;
    while (holdoff) begin hcount++; @(negedge clk); end
    check("R3 gap length", hcount, 20);

    access(1'b0, 4'd3, 8'h00, lat, rel, rv);
    check_range("R1 read latency", lat, 5, 7);
    check("R7 read back", rv, 8'h5A);
    access(1'b0, 4'd3, 8'h00, lat, rel, rv);
    check_range("R4 back-to-back read latency", lat, 23, 29);
    check("R7 read back again", rv, 8'h5A);
    access(1'b1, 4'd9, 8'hC3, lat, rel, rv);
    check_range("R4 back-to-back write latency", lat, 23, 29);
    check("R2 release after stalled", rel, 3);

    sw_reset = 1'b1;
    @(negedge clk);
    check("R6 holdoff off in sw reset", int'(holdoff), 0);
    access(1'b1, 4'd12, 8'h7E, lat, rel, rv);
    check_range("R6 sw reset access 1", lat, 5, 7);
    check("R6 no gap after access", int'(holdoff), 0);
    access(1'b0, 4'd9, 8'h00, lat, rel, rv);
    check_range("R6 sw reset access 2", lat, 5, 7);
    check("R7 read under sw reset", rv, 8'hC3);
    @(negedge clk);
    sw_reset = 1'b0;
    @(negedge clk);
    check("R6 no leftover gap", int'(holdoff), 0);
    access(1'b0, 4'd12, 8'h00, lat, rel, rv);
    check_range("R6 access after sw reset", lat, 5, 7);
    check("R7 read written in sw reset", rv, 8'h7E);
    access(1'b0, 4'd0, 8'h00, lat, rel, rv);
    check_range("R4 back-to-back after sw reset", lat, 23, 29);
    check("R7 unwritten word", rv, 0);
    repeat (25) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule